// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C bus target for a rotary position sensor. It runs on a fast system clock and oversamples the bus lines. It cleans each line with a spike filter and detects START and STOP conditions. It then shifts bytes in and out on SCL edges. It answers a single 7-bit bus address and pulls SDA low only to acknowledge a byte or to send a zero data bit.

The bus address has two parts. Five bits come from a writable configuration register; the top one of these is inverted on its way into the address. The two low bits come from strap pins. The first byte after an address with the write bit loads an 8-bit register pointer. Later bytes are written to the register the pointer selects, and the pointer steps by one after each byte. A read with a repeated START returns bytes from the pointer onward, also stepping by one.

The register space holds the address configuration and a 14-bit zero-position value, which the host can write. It also holds live sensor values, which are read-only. Each 14-bit value is split into an 8-bit high byte and a 6-bit low byte. When a read moves from a high byte to its matching low byte, the low byte comes from a copy taken when the high byte was fetched. The two halves therefore always come from the same sample.

Top module: `strap_i2c_target`

## Requirements
- R1: After reset SDA is released, the zero-position output is 0 and the configuration register is 0.
- R2: The bus address is {NOT cfg[4], cfg[3:0], strapPins[1], strapPins[0]}; with cfg = 0 and straps = 2'b10 it is 7'h42. The target acknowledges only an address byte that matches this address and leaves SDA released for any other address.
- R3: Register 8'h15 stores the 5 LSBs of a written byte. Reading it returns those 5 bits unchanged, with bit 4 reading 0 at reset, and bits 7:5 read 0.
- R4: Register 8'h16 holds zero position bits 13:6. Register 8'h17 holds bits 5:0 in its 6 LSBs; bits 7:6 of a byte written there are dropped and read back as 0. The stored value drives zeroPosOut, which changes only through such writes.
- R5: The read-only map is: 8'hFA = gain byte; 8'hFB = {4'b0, diag[3:0]}; 8'hFC/8'hFD = magnitude bits 13:6 and {2'b0, bits 5:0}; 8'hFE/8'hFF = angle with the same split. Every address outside this map and 8'h15-8'h17 reads 8'h00.
- R6: In a write transfer the first data byte sets the pointer. A repeated START followed by the address with the read bit then returns data starting at that pointer.
- R7: The pointer increments after every byte read or written and wraps from 8'hFF to 8'h00.
- R8: A read of 8'hFD or 8'hFF that directly follows, in the same transfer, the read of its high byte returns the low bits sampled when the high byte was loaded. Any other read of a low byte returns the live value.
- R9: Every data byte received after a matching address is acknowledged. Bytes written to read-only or unmapped addresses change no state.
- R10: After the master answers a read byte with NACK, the target stops driving SDA until the next START.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks, after the two-flop synchronizer, has no effect on the protocol.
- R12: SDA drive changes only while the filtered SCL is low, except for the release that follows a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| sdaDriveLow | output | 1 | 1 = pull SDA low (open-drain enable) |
| strapPins | input | 2 | Address strap pins, bit 1 above bit 0 |
| agcIn | input | 8 | Gain control value |
| diagIn | input | 4 | Diagnostic flags {compHigh, compLow, cordicOvf, offsetDone} |
| magIn | input | 14 | Field magnitude |
| angleIn | input | 14 | Angle value |
| zeroPosOut | output | 14 | Zero-position setting held in 8'h16/8'h17 |

## Verification
The bound checker watches several things on every cycle. SDA stays released whenever the protocol engine is idle, and a drive change away from START or STOP happens only with SCL low. An address acknowledge only follows a byte equal to the computed address. The zero position moves only after a write strobe, the filtered SCL only moves to a level the synchronizer has already shown, and at most one datapath strobe is active per cycle. The bench scenarios are what show the byte-level results: the address formed from the inverted config bit and the straps, register contents after page writes, the readout map and pointer wrap, the coherence of the low-byte snapshot against a value that changes mid-transfer, release after NACK, and rejection of short spikes on both lines.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;
  localparam int VAL_W  = 14;
  localparam int LO_W   = 6;
  localparam int HI_W   = VAL_W - LO_W;
  localparam int CFG_W  = 5;
  localparam int DIAG_W = 4;
  localparam int STRAP_W = 2;

  localparam logic [7:0] REG_CFG = 8'h15;
  localparam logic [7:0] REG_ZHI = 8'h16;
  localparam logic [7:0] REG_ZLO = 8'h17;
  localparam logic [7:0] REG_AGC = 8'hFA;
  localparam logic [7:0] REG_DIA = 8'hFB;
  localparam logic [7:0] REG_MHI = 8'hFC;
  localparam logic [7:0] REG_MLO = 8'hFD;
  localparam logic [7:0] REG_AHI = 8'hFE;
  localparam logic [7:0] REG_ALO = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } busState_t;

  typedef enum logic [1:0] { SNAP_NONE, SNAP_MAG, SNAP_ANG } snapKind_t;

  typedef struct packed {
    logic shiftRx;
    logic setPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic clearSnap;
  } dpStrobe_t;
endpackage

// File: rtl/strap_i2c_filter.sv
module strap_i2c_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic syncOut,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cleanOut <= 1'b1;
      runCnt   <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        cleanOut <= syncQ[1];
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign syncOut = syncQ[1];
endmodule

// File: rtl/strap_i2c_ctrl.sv
module strap_i2c_ctrl
  import strap_i2c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic [7:0] rxByte,
  input  logic      txBit,
  input  logic [6:0] devAddr,
  output dpStrobe_t stb,
  output busState_t state,
  output logic      startEv,
  output logic      stopEv,
  output logic      sdaDriveLow
);
  logic      sclPrev, sdaPrev, ackDrive, ptrDone;
  logic [3:0] bitCnt;
  busState_t nextState;
  logic      nextAck, nextPtrDone;
  logic [3:0] nextCnt;
  logic      sclRise, sclFall;

  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startEv = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopEv  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_comb begin
    stb         = '0;
    nextState   = state;
    nextCnt     = bitCnt;
    nextAck     = ackDrive;
    nextPtrDone = ptrDone;
    if (stopEv) begin
      nextState     = ST_IDLE;
      nextAck       = 1'b0;
      stb.clearSnap = 1'b1;
    end else if (startEv) begin
      nextState     = ST_ADDR;
      nextCnt       = '0;
      nextAck       = 1'b0;
      nextPtrDone   = 1'b0;
      stb.clearSnap = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt != 4'd8) begin
            stb.shiftRx = 1'b1;
            nextCnt     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == devAddr) begin
                nextState = ST_ADDR_ACK;
                nextAck   = 1'b1;
              end else begin
                nextState = ST_IDLE;
              end
            end else begin
              nextState = ST_RX_ACK;
              nextAck   = 1'b1;
              if (ptrDone) stb.writeReg = 1'b1;
              else begin
                stb.setPtr  = 1'b1;
                nextPtrDone = 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            nextAck = 1'b0;
            nextCnt = '0;
            if (rxByte[0]) begin
              nextState  = ST_TX;
              stb.loadTx = 1'b1;
            end else begin
              nextState = ST_RX;
            end
          end
        end
        ST_RX_ACK: begin
          if (sclFall) begin
            nextState = ST_RX;
            nextAck   = 1'b0;
            nextCnt   = '0;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) nextState = ST_TX_ACK;
            else begin
              stb.shiftTx = 1'b1;
              nextCnt     = bitCnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise && sdaF) begin
            nextState = ST_IDLE;
          end else if (sclFall) begin
            nextState  = ST_TX;
            stb.loadTx = 1'b1;
            nextCnt    = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      ptrDone  <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      state    <= nextState;
      bitCnt   <= nextCnt;
      ackDrive <= nextAck;
      ptrDone  <= nextPtrDone;
      sclPrev  <= sclF;
      sdaPrev  <= sdaF;
    end
  end

  assign sdaDriveLow = ackDrive | ((state == ST_TX) & ~txBit);
endmodule

// File: rtl/strap_i2c_dp.sv
module strap_i2c_dp
  import strap_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic               sdaF,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [7:0]         agcIn,
  input  logic [DIAG_W-1:0]  diagIn,
  input  logic [VAL_W-1:0]   magIn,
  input  logic [VAL_W-1:0]   angleIn,
  output logic [7:0]         rxByte,
  output logic               txBit,
  output logic [6:0]         devAddr,
  output logic [VAL_W-1:0]   zeroPosOut
);
  logic [7:0]       txShift, regPtr, rdData;
  logic [CFG_W-1:0] cfgReg;
  logic [HI_W-1:0]  zeroHi;
  logic [LO_W-1:0]  zeroLo, snapLow;
  snapKind_t        snapKind;

  function automatic logic [7:0] loByte(input logic [LO_W-1:0] v);
    return {{(8 - LO_W){1'b0}}, v};
  endfunction

  always_comb begin
    case (regPtr)
      REG_CFG: rdData = {{(8 - CFG_W){1'b0}}, cfgReg};
      REG_ZHI: rdData = zeroHi;
      REG_ZLO: rdData = loByte(zeroLo);
      REG_AGC: rdData = agcIn;
      REG_DIA: rdData = {{(8 - DIAG_W){1'b0}}, diagIn};
      REG_MHI: rdData = magIn[VAL_W-1:LO_W];
      REG_MLO: rdData = loByte((snapKind == SNAP_MAG) ? snapLow : magIn[LO_W-1:0]);
      REG_AHI: rdData = angleIn[VAL_W-1:LO_W];
      REG_ALO: rdData = loByte((snapKind == SNAP_ANG) ? snapLow : angleIn[LO_W-1:0]);
      default: rdData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte   <= '0;
      txShift  <= 8'hFF;
      regPtr   <= '0;
      cfgReg   <= '0;
      zeroHi   <= '0;
      zeroLo   <= '0;
      snapLow  <= '0;
      snapKind <= SNAP_NONE;
    end else begin
      if (stb.shiftRx) rxByte <= {rxByte[6:0], sdaF};
      if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
      if (stb.setPtr) regPtr <= rxByte;
      if (stb.clearSnap) snapKind <= SNAP_NONE;
      if (stb.writeReg) begin
        case (regPtr)
          REG_CFG: cfgReg <= rxByte[CFG_W-1:0];
          REG_ZHI: zeroHi <= rxByte;
          REG_ZLO: zeroLo <= rxByte[LO_W-1:0];
          default: ;
        endcase
        regPtr <= regPtr + 8'd1;
      end
      if (stb.loadTx) begin
        txShift <= rdData;
        regPtr  <= regPtr + 8'd1;
        case (regPtr)
          REG_MHI: begin snapKind <= SNAP_MAG; snapLow <= magIn[LO_W-1:0]; end
          REG_AHI: begin snapKind <= SNAP_ANG; snapLow <= angleIn[LO_W-1:0]; end
          default: snapKind <= SNAP_NONE;
        endcase
      end
    end
  end

  assign txBit      = txShift[7];
  assign devAddr    = {~cfgReg[CFG_W-1], cfgReg[CFG_W-2:0], strapPins};
  assign zeroPosOut = {zeroHi, zeroLo};
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
  import strap_i2c_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  input  logic [STRAP_W-1:0] strapPins,
  input  logic [7:0]         agcIn,
  input  logic [DIAG_W-1:0]  diagIn,
  input  logic [VAL_W-1:0]   magIn,
  input  logic [VAL_W-1:0]   angleIn,
  output logic [VAL_W-1:0]   zeroPosOut
);
  logic [1:0] rawLines, syncLines, cleanLines;
  logic       sclClean, sdaClean, sclSync;
  dpStrobe_t  stb;
  busState_t  state;
  logic       startEv, stopEv, txBit;
  logic [7:0] rxByte;
  logic [6:0] devAddr;

  assign rawLines = {sdaIn, sclIn};

  for (genvar li = 0; li < 2; li++) begin : g_line
    strap_i2c_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[li]),
      .syncOut(syncLines[li]), .cleanOut(cleanLines[li])
    );
  end

  assign sclClean = cleanLines[0];
  assign sdaClean = cleanLines[1];
  assign sclSync  = syncLines[0];

  strap_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclClean), .sdaF(sdaClean),
    .rxByte(rxByte), .txBit(txBit), .devAddr(devAddr),
    .stb(stb), .state(state), .startEv(startEv), .stopEv(stopEv),
    .sdaDriveLow(sdaDriveLow)
  );

  strap_i2c_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaF(sdaClean),
    .strapPins(strapPins), .agcIn(agcIn), .diagIn(diagIn),
    .magIn(magIn), .angleIn(angleIn), .rxByte(rxByte), .txBit(txBit),
    .devAddr(devAddr), .zeroPosOut(zeroPosOut)
  );
endmodule

// File: rtl/strap_i2c_chk.sv
module strap_i2c_chk
  import strap_i2c_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sclF,
  input logic             sclSync,
  input logic             sdaDriveLow,
  input busState_t        state,
  input logic             startEv,
  input logic             stopEv,
  input dpStrobe_t        stb,
  input logic [7:0]       rxByte,
  input logic [6:0]       devAddr,
  input logic [VAL_W-1:0] zeroPosOut
);
  p_release_in_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDriveLow);

  p_ack_on_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK && $past(state) != ST_ADDR_ACK) |-> (rxByte[7:1] == devAddr));

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaDriveLow != $past(sdaDriveLow)) && !$past(startEv || stopEv)) |-> !sclF);

  p_zero_on_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.writeReg) |-> $stable(zeroPosOut));

  p_filter_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sclF != $past(sclF)) |-> ($past(sclSync) == sclF));

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setPtr, stb.writeReg, stb.loadTx, stb.shiftTx, stb.shiftRx}));
endmodule

bind strap_i2c_target strap_i2c_chk u_chk (
  .clk(clk), .rstN(rstN), .sclF(sclClean), .sclSync(sclSync),
  .sdaDriveLow(sdaDriveLow), .state(state), .startEv(startEv), .stopEv(stopEv),
  .stb(stb), .rxByte(rxByte), .devAddr(devAddr), .zeroPosOut(zeroPosOut)
);

// File: tb/strap_i2c_target_tb.sv
module strap_i2c_target_tb;
  localparam int Q = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclLine, sdaLine, sdaDriveLow;
  logic [1:0] strapPins = 2'b10;
  logic [7:0] agcIn = 8'h00;
  logic [3:0] diagIn = 4'h0;
  logic [13:0] magIn = '0, angleIn = '0, zeroPosOut;
  int vectors = 0, miscompares = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] obsQ[$];

  always #10 clk = ~clk;
  assign sclLine = ~mSclLow;
  assign sdaLine = ~(mSdaLow | sdaDriveLow);

  strap_i2c_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .strapPins(strapPins), .agcIn(agcIn),
    .diagIn(diagIn), .magIn(magIn), .angleIn(angleIn), .zeroPosOut(zeroPosOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectRd(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // monitor: compares observed read bytes against the expected queue
  initial forever begin
    logic [7:0] got, exp;
    string tag;
    wait (obsQ.size() > 0);
    got = obsQ.pop_front();
    if (expQ.size() == 0) begin exp = ~got; tag = "R5 unexpected"; end
    else begin exp = expQ.pop_front(); tag = tagQ.pop_front(); end
    check(got == exp, tag, {8'h0, got}, {8'h0, exp});
  end

  task automatic startCond();
    mSdaLow = 1'b0; tick(Q);
    mSclLow = 1'b0; tick(Q);
    mSdaLow = 1'b1; tick(Q);
    mSclLow = 1'b1; tick(Q);
  endtask

  task automatic stopCond();
    mSdaLow = 1'b1; tick(Q);
    mSclLow = 1'b0; tick(Q);
    mSdaLow = 1'b0; tick(2 * Q);
  endtask

  task automatic writeByte(input logic [7:0] b, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      mSdaLow = ~b[i];
      if (glitch && i == 4) begin mSclLow = 1'b0; tick(2); mSclLow = 1'b1; end
      tick(Q);
      mSclLow = 1'b0;
      if (glitch && i == 3 && b[i]) begin tick(4); mSdaLow = 1'b1; tick(2); mSdaLow = 1'b0; tick(2 * Q - 8); end
      else tick(2 * Q);
      mSclLow = 1'b1;
    end
    tick(2);
    mSdaLow = 1'b0;
    tick(2 * Q - 2);
    mSclLow = 1'b0;
    tick(Q);
    ack = sdaLine;
    tick(Q);
    mSclLow = 1'b1;
  endtask

  task automatic readByte(input logic ackIt, input logic toScore, output logic [7:0] v);
    logic early;
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(2 * Q);
      mSclLow = 1'b0;
      tick(Q / 2);
      early = sdaLine;
      tick(Q / 2);
      v[i] = sdaLine;
      tick(Q - 1);
      check(sdaLine == early, "R12 sda moved while scl high", {15'h0, sdaLine}, {15'h0, early});
      tick(1);
      mSclLow = 1'b1;
    end
    tick(Q);
    mSdaLow = ackIt;
    tick(Q);
    mSclLow = 1'b0;
    tick(2 * Q);
    mSclLow = 1'b1;
    tick(2);
    mSdaLow = 1'b0;
    if (toScore) obsQ.push_back(v);
  endtask

  task automatic addrPhase(input logic [6:0] a, input logic rd, input logic expAck, input string tag);
    logic ack;
    writeByte({a, rd}, 1'b0, ack);
    check(ack == ~expAck, tag, {15'h0, ack}, {15'h0, ~expAck});
  endtask

  task automatic writeRegs(input logic [6:0] a, input logic [7:0] ptr, input int n,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                           input logic glitch);
    logic ack;
    logic [7:0] d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    startCond();
    writeByte({a, 1'b0}, glitch, ack);
    check(ack == 1'b0, "R11/R2 address ack", {15'h0, ack}, 16'h0);
    writeByte(ptr, glitch, ack);
    check(ack == 1'b0, "R9 pointer ack", {15'h0, ack}, 16'h0);
    for (int i = 0; i < n; i++) begin
      writeByte(d[i], glitch, ack);
      check(ack == 1'b0, "R9 data ack", {15'h0, ack}, 16'h0);
    end
    stopCond();
  endtask

  task automatic readRegs(input logic [6:0] a, input logic [7:0] ptr, input int n);
    logic ack;
    logic [7:0] v;
    startCond();
    addrPhase(a, 1'b0, 1'b1, "R2 write address ack");
    writeByte(ptr, 1'b0, ack);
    check(ack == 1'b0, "R6 pointer ack", {15'h0, ack}, 16'h0);
    startCond();
    addrPhase(a, 1'b1, 1'b1, "R6 read address ack");
    for (int i = 0; i < n; i++) readByte(i != n - 1, 1'b1, v);
    check(sdaDriveLow == 1'b0, "R10 released after nack", {15'h0, sdaDriveLow}, 16'h0);
    stopCond();
  endtask

  initial begin
    logic [7:0] v;
    logic ack;
    logic [13:0] oldMag;
    mSclLow = 1'b0; mSdaLow = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(5);
    check(sdaDriveLow == 1'b0, "R1 sda released", {15'h0, sdaDriveLow}, 16'h0);
    check(zeroPosOut == 14'h0, "R1 zero position", {2'b0, zeroPosOut}, 16'h0);

    // R3 config reads 0 at reset, R6 random read
    expectRd(8'h00, "R3 config reset value");
    readRegs(7'h42, 8'h15, 1);

    // R2 wrong address is not acknowledged
    startCond();
    addrPhase(7'h43, 1'b0, 1'b0, "R2 foreign address nack");
    stopCond();

    // R4 page write of zero position, low byte bits 7:6 dropped
    writeRegs(7'h42, 8'h16, 2, 8'hAB, 8'hFF, 8'h00, 1'b0);
    check(zeroPosOut == {8'hAB, 6'h3F}, "R4 zero position out", {2'b0, zeroPosOut}, {2'b0, 8'hAB, 6'h3F});
    expectRd(8'hAB, "R4 zero high readback");
    expectRd(8'h3F, "R4 zero low readback");
    readRegs(7'h42, 8'h16, 2);

    // R3/R2 config write changes address; bit 4 inverted
    writeRegs(7'h42, 8'h15, 1, 8'hF3, 8'h00, 8'h00, 1'b0);
    startCond();
    addrPhase(7'h42, 1'b0, 1'b0, "R2 old address rejected");
    stopCond();
    expectRd(8'h13, "R3 config keeps 5 LSBs");
    readRegs(7'h0E, 8'h15, 1);
    writeRegs(7'h0E, 8'h15, 1, 8'h00, 8'h00, 8'h00, 1'b0);
    startCond();
    addrPhase(7'h42, 1'b0, 1'b1, "R2 default address restored");
    stopCond();

    // R2 strap pins feed address LSBs
    strapPins = 2'b01;
    startCond();
    addrPhase(7'h41, 1'b0, 1'b1, "R2 strap address");
    stopCond();
    strapPins = 2'b10;

    // R5/R7 sequential readout with wrap
    agcIn = 8'h5A; diagIn = 4'hA; magIn = 14'h1234; angleIn = 14'h3ABC;
    expectRd(8'h5A, "R5 gain");
    expectRd(8'h0A, "R5 diag");
    expectRd(magIn[13:6], "R5 mag high");
    expectRd({2'b0, magIn[5:0]}, "R5 mag low");
    expectRd(angleIn[13:6], "R5 angle high");
    expectRd({2'b0, angleIn[5:0]}, "R5 angle low");
    expectRd(8'h00, "R7 pointer wrap to 00");
    readRegs(7'h42, 8'hFA, 7);

    // R8 snapshot coherence
    magIn = 14'h0FC1;
    oldMag = magIn;
    startCond();
    addrPhase(7'h42, 1'b0, 1'b1, "R2 address");
    writeByte(8'hFC, 1'b0, ack);
    startCond();
    addrPhase(7'h42, 1'b1, 1'b1, "R6 read address");
    expectRd(oldMag[13:6], "R8 high byte");
    readByte(1'b1, 1'b1, v);
    magIn = 14'h3F3E;
    expectRd({2'b0, oldMag[5:0]}, "R8 low byte from snapshot");
    readByte(1'b0, 1'b1, v);
    stopCond();
    expectRd({2'b0, magIn[5:0]}, "R8 lone low byte is live");
    readRegs(7'h42, 8'hFD, 1);

    // R9 writes to read-only and unmapped addresses have no effect
    writeRegs(7'h42, 8'h40, 1, 8'h77, 8'h00, 8'h00, 1'b0);
    writeRegs(7'h42, 8'hFF, 2, 8'h11, 8'h22, 8'h00, 1'b0);
    check(zeroPosOut == {8'hAB, 6'h3F}, "R9 zero unchanged", {2'b0, zeroPosOut}, {2'b0, 8'hAB, 6'h3F});
    expectRd(8'h00, "R9 unmapped stays zero");
    readRegs(7'h42, 8'h40, 1);

    // R10 after nack, further clocks see SDA released
    expectRd(8'h5A, "R10 gain before nack");
    readRegs(7'h42, 8'hFA, 1);
    startCond();
    addrPhase(7'h42, 1'b1, 1'b1, "R10 read address");
    readByte(1'b0, 1'b0, v);
    readByte(1'b0, 1'b0, v);
    check(v == 8'hFF, "R10 no drive after nack", {8'h0, v}, 16'h00FF);
    stopCond();

    // R11 spikes on SCL and SDA during a write are filtered
    writeRegs(7'h42, 8'h16, 2, 8'h5D, 8'h2A, 8'h00, 1'b1);
    check(zeroPosOut == {8'h5D, 6'h2A}, "R11 write with spikes", {2'b0, zeroPosOut}, {2'b0, 8'h5D, 6'h2A});

    tick(20);
    check(expQ.size() == 0, "R5 all reads observed", 16'(expQ.size()), 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule